// File: doc/BRIEF.md
# Sectored Cache Array Debug Port

This block holds the storage of a four-way set-associative, sectored second-level cache and gives software a direct path into it. Each set has one sector per way. A sector shares one tag and one LRU field between its two lines, and each line keeps its own MESI state. The lookup, fill, replacement and snoop logic are not part of the block. Only the arrays and a debug port that reads or writes one location per command are built.

A command carries a read/write flag and a location word. The location word picks either the tag side or the data side, and it names the way, the set, the line, the octet and the dword half. A data command moves one 32-bit dword. A tag command moves the whole sector descriptor, packed into one 32-bit word. A read answers one clock later with a single-cycle valid pulse. A write gives no answer.

Top module: `cdbg_sector_cache`

## Requirements
- R1: There are 4 ways of 1024 sets each, and every (way, set) pair is stored on its own. A write to one pair leaves every other pair unchanged.
- R2: The location word is 19 bits wide. Bit 2 selects the dword (1 = upper, 0 = lower). Bits 4:3 give the octet. Bit 5 selects the line (1 = line 1, 0 = line 0). Bits 15:6 give the set and bits 17:16 give the way. Bit 18 selects the array (1 = tag, 0 = data). Bits 1:0 are ignored.
- R3: A data write stores exactly one dword. A later data read of the same location returns it, and the other 15 dwords of the sector keep their values.
- R4: A read command produces rsp_valid high for exactly one cycle, on the clock after the command. A write command or an idle cycle produces rsp_valid low on the following cycle.
- R5: The tag word is laid out as follows: [1:0] line 0 MESI, [3:2] line 1 MESI, [6:4] LRU, [11:7] reserved, [31:12] tag. A tag write updates all fields at once. The reserved bits always read as 0.
- R6: The MESI codes are 00 Invalid, 01 Shared, 10 Exclusive and 11 Modified. After reset, every tag word reads as 0, which means both lines are Invalid, the LRU is 0 and the tag is 0.
- R7: A tag access ignores the line, octet and dword bits. Both lines of a sector reach the same tag word.
- R8: After reset, rsp_rdata is 0. It keeps its value in every cycle that has no read response.
- R9: The line bit selects separate storage. Line 0 and line 1 of one sector, at the same octet and dword, hold different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_loc | input | 19 | Location word (array, way, set, line, octet, dword) |
| req_wdata | input | 32 | Write data (a dword or a packed tag word) |
| rsp_valid | output | 1 | Read result is present |
| rsp_rdata | output | 32 | Read result; held between responses |

## Verification
Every read result, whether from the tag side or the data side, is due exactly one clock after the command. A write becomes visible to a read issued on the very next clock.

The bench drives commands at the falling edge. At the same falling edge it compares the outputs against what its own model predicted for the command issued one edge earlier, so each expectation lines up with exactly one register stage. In cycles with no response, the bench also checks that the held output has not moved. Back-to-back write/read pairs cover the case of a read that immediately follows a write.

// File: rtl/cdbg_pkg.sv
package cdbg_pkg;

  localparam int unsigned DWORD_W = 32;
  localparam int unsigned MESI_W  = 2;

  typedef enum logic [MESI_W-1:0] {
    MESI_INV = 2'b00,
    MESI_SHR = 2'b01,
    MESI_EXC = 2'b10,
    MESI_MOD = 2'b11
  } mesi_e;

endpackage

// File: rtl/cdbg_loc_decode.sv
module cdbg_loc_decode #(
  parameter int unsigned SET_BITS = 10,
  parameter int unsigned WAY_BITS = 2,
  parameter int unsigned OCT_BITS = 2,
  localparam int unsigned DW_BIT   = 2,
  localparam int unsigned OCT_LSB  = DW_BIT + 1,
  localparam int unsigned LINE_BIT = OCT_LSB + OCT_BITS,
  localparam int unsigned SET_LSB  = LINE_BIT + 1,
  localparam int unsigned WAY_LSB  = SET_LSB + SET_BITS,
  localparam int unsigned KIND_BIT = WAY_LSB + WAY_BITS,
  localparam int unsigned LOC_W    = KIND_BIT + 1,
  localparam int unsigned SLOT_W   = OCT_BITS + 2
) (
  input  logic [LOC_W-1:0]    loc,
  output logic                to_tag,
  output logic [WAY_BITS-1:0] way,
  output logic [SET_BITS-1:0] set_idx,
  output logic [SLOT_W-1:0]   slot
);

  logic loc_unused;

  // Byte-offset bits carry no meaning for a dword-wide port.
  assign loc_unused = ^loc[DW_BIT-1:0];

  always_comb begin
    to_tag  = loc[KIND_BIT];
    way     = loc[KIND_BIT-1:WAY_LSB];
    set_idx = loc[WAY_LSB-1:SET_LSB];
    // Slot order inside a sector: line, then octet, then dword half.
    slot    = {loc[LINE_BIT], loc[LINE_BIT-1:OCT_LSB], loc[DW_BIT]};
  end

endmodule

// File: rtl/cdbg_data_way.sv
module cdbg_data_way #(
  parameter int unsigned SETS    = 1024,
  parameter int unsigned SLOTS   = 16,
  parameter int unsigned DWORD_W = 32,
  localparam int unsigned SET_BITS = $clog2(SETS),
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned ROW_W    = SLOTS * DWORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [SET_BITS-1:0] set_idx,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [DWORD_W-1:0]  wdata,
  output logic [DWORD_W-1:0]  rd_q
);

  logic [ROW_W-1:0]   row_mem [SETS];
  logic [DWORD_W-1:0] rd_d;

  // Storage carries no reset; its contents are undefined until written.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      row_mem[set_idx][slot*DWORD_W +: DWORD_W] <= wdata;
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = row_mem[set_idx][slot*DWORD_W +: DWORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/cdbg_tag_way.sv
module cdbg_tag_way
  import cdbg_pkg::*;
#(
  parameter int unsigned SETS  = 1024,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned LRU_W = 3,
  localparam int unsigned SET_BITS = $clog2(SETS),
  localparam int unsigned ENT_W    = TAG_W + LRU_W + 2 * MESI_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [SET_BITS-1:0] set_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [LRU_W-1:0]    wr_lru,
  input  mesi_e               wr_mesi0,
  input  mesi_e               wr_mesi1,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [LRU_W-1:0]    rd_lru,
  output mesi_e               rd_mesi0,
  output mesi_e               rd_mesi1
);

  logic [ENT_W-1:0] ent_mem [SETS];
  logic [SETS-1:0]  live_q;
  logic [SETS-1:0]  live_d;
  logic [ENT_W-1:0] ent_rd;
  logic [ENT_W-1:0] rdq_q;
  logic [ENT_W-1:0] rdq_d;

  // Entry array: no reset; a per-set live bit masks stale contents.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_mem[set_idx] <= {wr_tag, wr_lru, wr_mesi1, wr_mesi0};
    end
  end

  always_comb begin
    live_d = live_q;
    if (wr_en) begin
      live_d[set_idx] = 1'b1;
    end
  end

  always_comb begin
    ent_rd = live_q[set_idx] ? ent_mem[set_idx] : '0;
    rdq_d  = rd_en ? ent_rd : rdq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      rdq_q  <= '0;
    end else begin
      live_q <= live_d;
      rdq_q  <= rdq_d;
    end
  end

  always_comb begin
    rd_tag   = rdq_q[ENT_W-1 -: TAG_W];
    rd_lru   = rdq_q[2*MESI_W +: LRU_W];
    rd_mesi1 = mesi_e'(rdq_q[MESI_W +: MESI_W]);
    rd_mesi0 = mesi_e'(rdq_q[0 +: MESI_W]);
  end

endmodule

// File: rtl/cdbg_sector_cache.sv
module cdbg_sector_cache
  import cdbg_pkg::*;
#(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned SETS   = 1024,
  parameter int unsigned OCTETS = 4,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned LRU_W  = 3,
  localparam int unsigned WAY_BITS = $clog2(WAYS),
  localparam int unsigned SET_BITS = $clog2(SETS),
  localparam int unsigned OCT_BITS = $clog2(OCTETS),
  localparam int unsigned SLOTS    = 2 * OCTETS * 2,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned LOC_W    = 3 + OCT_BITS + 1 + SET_BITS + WAY_BITS + 1,
  localparam int unsigned RSV_W    = DWORD_W - TAG_W - LRU_W - 2 * MESI_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [LOC_W-1:0]   req_loc,
  input  logic [DWORD_W-1:0] req_wdata,
  output logic               rsp_valid,
  output logic [DWORD_W-1:0] rsp_rdata
);

  logic                to_tag;
  logic [WAY_BITS-1:0] way;
  logic [SET_BITS-1:0] set_idx;
  logic [SLOT_W-1:0]   slot;

  logic                rd_req;
  logic                wr_req;
  logic                rsp_valid_q;
  logic                rsp_valid_d;
  logic                kind_q;
  logic                kind_d;
  logic [WAY_BITS-1:0] way_q;
  logic [WAY_BITS-1:0] way_d;

  logic [TAG_W-1:0]   wr_tag;
  logic [LRU_W-1:0]   wr_lru;
  mesi_e              wr_mesi0;
  mesi_e              wr_mesi1;
  logic [RSV_W-1:0]   wr_rsv_unused;

  logic [DWORD_W-1:0] data_rd  [WAYS];
  logic [TAG_W-1:0]   tag_rd   [WAYS];
  logic [LRU_W-1:0]   lru_rd   [WAYS];
  mesi_e              mesi0_rd [WAYS];
  mesi_e              mesi1_rd [WAYS];

  cdbg_loc_decode #(
    .SET_BITS (SET_BITS),
    .WAY_BITS (WAY_BITS),
    .OCT_BITS (OCT_BITS)
  ) u_decode (
    .loc     (req_loc),
    .to_tag  (to_tag),
    .way     (way),
    .set_idx (set_idx),
    .slot    (slot)
  );

  // Unpack the tag-side write word; reserved bits are dropped.
  always_comb begin
    wr_mesi0      = mesi_e'(req_wdata[0 +: MESI_W]);
    wr_mesi1      = mesi_e'(req_wdata[MESI_W +: MESI_W]);
    wr_lru        = req_wdata[2*MESI_W +: LRU_W];
    wr_rsv_unused = req_wdata[2*MESI_W + LRU_W +: RSV_W];
    wr_tag        = req_wdata[DWORD_W-1 -: TAG_W];
  end

  always_comb begin
    rd_req = req_valid & ~req_write;
    wr_req = req_valid &  req_write;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic hit_way;
    assign hit_way = (way == WAY_BITS'(w));

    cdbg_data_way #(
      .SETS    (SETS),
      .SLOTS   (SLOTS),
      .DWORD_W (DWORD_W)
    ) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_req & ~to_tag & hit_way),
      .rd_en   (rd_req & ~to_tag & hit_way),
      .set_idx (set_idx),
      .slot    (slot),
      .wdata   (req_wdata),
      .rd_q    (data_rd[w])
    );

    cdbg_tag_way #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .LRU_W (LRU_W)
    ) u_tag (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_req & to_tag & hit_way),
      .rd_en    (rd_req & to_tag & hit_way),
      .set_idx  (set_idx),
      .wr_tag   (wr_tag),
      .wr_lru   (wr_lru),
      .wr_mesi0 (wr_mesi0),
      .wr_mesi1 (wr_mesi1),
      .rd_tag   (tag_rd[w]),
      .rd_lru   (lru_rd[w]),
      .rd_mesi0 (mesi0_rd[w]),
      .rd_mesi1 (mesi1_rd[w])
    );
  end

  // Response selection state follows the last read only.
  always_comb begin
    rsp_valid_d = rd_req;
    kind_d      = rd_req ? to_tag : kind_q;
    way_d       = rd_req ? way    : way_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      kind_q      <= 1'b0;
      way_q       <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      kind_q      <= kind_d;
      way_q       <= way_d;
    end
  end

  always_comb begin
    rsp_valid = rsp_valid_q;
    if (kind_q) begin
      rsp_rdata = {tag_rd[way_q], {RSV_W{1'b0}}, lru_rd[way_q],
                   mesi1_rd[way_q], mesi0_rd[way_q]};
    end else begin
      rsp_rdata = data_rd[way_q];
    end
  end

endmodule

// File: rtl/cdbg_sector_cache_chk.sv
module cdbg_sector_cache_chk #(
  parameter int unsigned LOC_W    = 19,
  parameter int unsigned KIND_BIT = 18,
  parameter int unsigned SET_LSB  = 6,
  parameter logic [31:0] TAG_MASK = 32'hFFFF_F07F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [LOC_W-1:0] req_loc,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata
);

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R4

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R4

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata)); // R8

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_loc[KIND_BIT])) |-> ((rsp_rdata & ~TAG_MASK) == 32'h0)); // R5

  AST_DATA_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_loc[KIND_BIT] &&
     $past(req_valid && req_write) && (req_loc == $past(req_loc)))
    |=> (rsp_rdata == $past(req_wdata, 2))); // R3

  AST_TAG_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_loc[KIND_BIT] &&
     $past(req_valid && req_write && req_loc[KIND_BIT]) &&
     (req_loc[KIND_BIT-1:SET_LSB] == $past(req_loc[KIND_BIT-1:SET_LSB])))
    |=> ((rsp_rdata & TAG_MASK) == ($past(req_wdata, 2) & TAG_MASK))); // R7

endmodule

bind cdbg_sector_cache cdbg_sector_cache_chk #(
  .LOC_W    (LOC_W),
  .KIND_BIT (LOC_W - 1),
  .SET_LSB  (3 + OCT_BITS + 1),
  .TAG_MASK (~(((32'h1 << RSV_W) - 32'h1) << (2 * cdbg_pkg::MESI_W + LRU_W)))
) u_chk (.*);

// File: tb/test_cdbg_sector_cache.sv
module test_cdbg_sector_cache;

  localparam logic [31:0] TMASK = 32'hFFFF_F07F;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [18:0] req_loc;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks;
  int fails;

  int unsigned data_m [int];
  int unsigned tag_m  [int];

  logic        exp_v;
  logic [31:0] exp_d;
  string       exp_lbl;
  logic [31:0] last_d;

  cdbg_sector_cache i_cdbg_sector_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_loc   (req_loc),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [18:0] mk(input bit tg, input int w, input int s,
                                     input int ln, input int oc, input int dw);
    logic [1:0] wb = w[1:0];
    logic [9:0] sb = s[9:0];
    logic [1:0] ob = oc[1:0];
    return {tg, wb, sb, ln[0], ob, dw[0], 2'b01};
  endfunction

  function automatic int dkey(input logic [18:0] l);
    return int'(l[17:2]);
  endfunction

  function automatic int tkey(input logic [18:0] l);
    return int'(l[17:6]);
  endfunction

  task automatic fail_line(input string req, input logic [31:0] act, input logic [31:0] exp);
    fails++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  // One clock: check the previous command's outcome, then drive the next.
  task automatic step(input bit v, input bit w, input logic [18:0] l,
                      input logic [31:0] wd, input string lbl);
    @(negedge clk);
    checks++;
    if (rsp_valid !== exp_v) fail_line("R4 rsp_valid", 32'(rsp_valid), 32'(exp_v));
    checks++;
    if (exp_v) begin
      if (rsp_rdata !== exp_d) fail_line(exp_lbl, rsp_rdata, exp_d);
    end else begin
      if (rsp_rdata !== last_d) fail_line("R8 hold", rsp_rdata, last_d);
    end
    last_d = rsp_rdata;
    req_valid = v;
    req_write = w;
    req_loc   = l;
    req_wdata = wd;
    if (v && w) begin
      if (l[18]) tag_m[tkey(l)] = wd & TMASK;
      else       data_m[dkey(l)] = wd;
    end
    exp_v   = v && !w;
    exp_lbl = lbl;
    if (exp_v) begin
      if (l[18]) exp_d = tag_m.exists(tkey(l)) ? tag_m[tkey(l)] : 32'h0;
      else       exp_d = data_m.exists(dkey(l)) ? data_m[dkey(l)] : 32'hX;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    summary();
  end

  initial begin
    checks = 0; fails = 0;
    exp_v = 1'b0; exp_d = '0; exp_lbl = ""; last_d = '0;
    req_valid = 1'b0; req_write = 1'b0; req_loc = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8 / R4: reset state of the response outputs.
    checks++;
    if (rsp_valid !== 1'b0) fail_line("R4 reset valid", 32'(rsp_valid), 32'h0);
    checks++;
    if (rsp_rdata !== 32'h0) fail_line("R8 reset rdata", rsp_rdata, 32'h0);
    rst_n = 1'b1;

    // R6: every tag word is zero after reset.
    for (int w = 0; w < 4; w++) begin
      step(1, 0, mk(1, w, 0, 0, 0, 0),       '0, "R6 tag after reset");
      step(1, 0, mk(1, w, 1023, 1, 3, 1),    '0, "R6 tag after reset");
    end

    // R1 / R2: distinct way/set pairs hold distinct data.
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 4; k++) begin
        int s = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 513 : 1023;
        step(1, 1, mk(0, w, s, k & 1, k, (w + k) & 1),
             32'hA500_0000 ^ (w << 20) ^ (s << 4) ^ k, "R1 write");
      end
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 4; k++) begin
        int s = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 513 : 1023;
        step(1, 0, mk(0, w, s, k & 1, k, (w + k) & 1), '0, "R1 R2 readback");
      end

    // R3 / R9: fill one whole sector, then overwrite one dword.
    for (int i = 0; i < 16; i++)
      step(1, 1, mk(0, 2, 77, i >> 3, (i >> 1) & 3, i & 1), 32'h1000_0000 + i * 32'h0101_0101, "R3 fill");
    for (int i = 0; i < 16; i++)
      step(1, 0, mk(0, 2, 77, i >> 3, (i >> 1) & 3, i & 1), '0, "R9 line/slot readback");
    step(1, 1, mk(0, 2, 77, 1, 2, 0), 32'hDEAD_BEEF, "R3 overwrite");
    for (int i = 0; i < 16; i++)
      step(1, 0, mk(0, 2, 77, i >> 3, (i >> 1) & 3, i & 1), '0, "R3 neighbours intact");

    // R4 / R3: write immediately followed by read of the same dword.
    for (int i = 0; i < 6; i++) begin
      step(1, 1, mk(0, i & 3, 300 + i, i & 1, i & 3, (i >> 1) & 1), 32'hC0DE_0000 + i, "R3 write");
      step(1, 0, mk(0, i & 3, 300 + i, i & 1, i & 3, (i >> 1) & 1), '0, "R4 R3 read after write");
    end

    // R5 / R6 / R7: tag writes via line 0 with reserved bits set, reads via line 1.
    for (int w = 0; w < 4; w++) begin
      logic [1:0] m0 = w[1:0];
      logic [1:0] m1 = 2'(3 - w);
      logic [31:0] tw = {20'hABC00 + 20'(w), 5'b11111, 3'(w + 5), m1, m0};
      step(1, 1, mk(1, w, 600 + w, 0, 0, 0), tw, "R5 tag write");
      step(1, 0, mk(1, w, 600 + w, 1, 3, 1), '0, "R7 R5 shared tag read");
      step(1, 0, mk(1, w, 601 + w + 4, 0, 1, 0), '0, "R6 untouched sector");
    end
    step(1, 0, mk(1, 1, 600, 0, 0, 0), '0, "R1 tag way isolation");
    step(1, 0, mk(0, 2, 77, 0, 0, 0), '0, "R3 data after tag traffic");

    // R4 / R8: writes and idles give no response; output holds.
    step(0, 0, '0, '0, "");
    step(1, 1, mk(0, 0, 5, 0, 0, 0), 32'h5555_AAAA, "R4 write only");
    step(0, 1, mk(0, 0, 5, 0, 0, 0), 32'hFFFF_FFFF, "");
    step(0, 0, '0, '0, "");
    step(1, 0, mk(0, 0, 5, 0, 0, 0), '0, "R4 read");
    step(0, 0, '0, '0, "");
    step(0, 0, '0, '0, "");
    summary();
  end

endmodule